// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block lets a bus master on a two-wire serial bus (SCL clock, open-drain SDA data) read and write a small bank of byte-wide registers, such as the wiper settings of a quad potentiometer. Both bus lines are oversampled by the system clock. After synchronization the block detects the START and STOP conditions and the SCL edges. A transaction opens with an identification byte. Its upper five bits are a fixed prefix and the next two bits must equal two strap inputs. A register address byte follows, then one or more data bytes. On a write the data bytes go from the master to the bank. On a read the slave returns the selected registers.

The slave never drives SDA high. It only asserts an output enable that pulls the line low, for its acknowledge bits and for the zero bits of read data. Toward the register bank it presents an address, a one-cycle write strobe with write data, and a read-data input. The bank is expected to return that read data combinationally for the presented address.

Top module: `i2cs_regport`

## Requirements
- R1: A START is SDA going high to low while SCL is high. A STOP is SDA going low to high while SCL is high. Every other SDA change must occur while SCL is low and is taken as data.
- R2: After reset `sda_oe` and `reg_wr` are 0. The slave ignores all clocking until it sees a START. A START made while reset is asserted is not recognized: bytes clocked after reset release, without a new START, get no acknowledge.
- R3: The identification byte is sent MSB first. Bits 7:3 must be 01010 and bits 2:1 must equal `strap_i[1:0]`. Bit 0 selects the direction: 1 is read, 0 is write. On a match the slave pulls SDA low during the ninth clock.
- R4: If the prefix or the strap bits do not match, the slave leaves SDA released on the ninth clock. It does not acknowledge any later byte until the next START.
- R5: The byte after a matched identification byte is the register address. It is always acknowledged, and its two low bits select one of four registers.
- R6: On a write, each data byte produces a single-cycle `reg_wr` pulse carrying `reg_addr` and `reg_wdata`. The slave then acknowledges that byte.
- R7: On a read, after the address is acknowledged, the slave shifts the selected register out MSB first and releases SDA for the ninth clock. A master acknowledge (SDA low) starts the next byte. A master NACK ends the read, and the slave drives nothing more until a START.
- R8: The register address advances by one after every data byte, whether written or read, and wraps from 3 to 0.
- R9: A STOP returns the slave to idle with SDA released. `sda_oe` only rises while the synchronized SCL is low, after a detected falling edge.
- R10: A repeated START in the middle of a transaction abandons it and begins a new identification byte. A partly received data byte is never written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 2 | Strap bits compared with identification bits 2:1 |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| reg_addr | output | 2 | Selected register index |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data for the selected register |
| reg_rdata | input | 8 | Read data of the selected register |

## Verification
On the SCL falling edge that follows the eighth bit of a written data byte, the write strobe and the start of the acknowledge drive are issued together. On the falling edge that ends a read byte, the address increment and the SDA release also happen together. The bench provokes the first case with back-to-back data bytes that cross the wrap from register 3 to register 0. It checks the acknowledge seen on the bus, and then reads the bank back to judge where each byte landed. It provokes the second case by reading across the same wrap and checking each returned byte, then sends a NACK and confirms that SDA stays released afterwards.

// File: rtl/i2cs_pkg.sv
// Shared types for the two-wire register slave.
// Assumes byte-wide bus transfers; nothing here is tunable per instance.
package i2cs_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    // Controller phase
    typedef enum logic [2:0] {
        ST_IDLE, // waiting for a START
        ST_RX,   // shifting in a byte
        ST_ACK,  // slave drives acknowledge bit
        ST_TX,   // shifting out a read byte
        ST_RACK  // master acknowledge slot after a read byte
    } phase_e;

    // Meaning of the byte being received
    typedef enum logic [1:0] {
        K_ID,
        K_ADDR,
        K_DATA
    } kind_e;
endpackage

// File: rtl/i2cs_sync.sv
// Multi-stage synchronizer for a group of asynchronous input lines.
// Lines reset to the idle-high level. primed_o rises only once the
// pipeline and one further history stage hold sampled values, so that
// a level present during reset is never seen as a transition.
module i2cs_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] in_i,
    output logic [LINES-1:0] out_o,
    output logic             primed_o
);
    localparam int FILL_MAX = STAGES + 1;
    localparam int FILL_W   = $clog2(FILL_MAX + 1);

    logic [FILL_W-1:0] fill;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        // Shift each line through its flop chain
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-2:0], in_i[g]};
        end
        assign out_o[g] = pipe[STAGES-1];
    end

    // Count cycles since reset until history is valid
    always_ff @(posedge clk) begin
        if (!rst_n)                        fill <= '0;
        else if (fill != FILL_W'(FILL_MAX)) fill <= fill + 1'b1;
    end

    assign primed_o = (fill == FILL_W'(FILL_MAX));
endmodule

// File: rtl/i2cs_cond.sv
// Bus event detector: SCL edges and START/STOP conditions from the
// synchronized lines. Assumes each bus level lasts several clocks.
module i2cs_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic primed_i,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);
    logic scl_q, sda_q;

    // One-cycle history of both lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign start_o    = primed_i & scl_s & scl_q & sda_q & ~sda_s;
    assign stop_o     = primed_i & scl_s & scl_q & ~sda_q & sda_s;
    assign scl_rise_o = primed_i & scl_s & ~scl_q;
    assign scl_fall_o = primed_i & ~scl_s & scl_q;
endmodule

// File: rtl/i2cs_ctrl.sv
// Transaction controller: identification byte, address byte, then data
// bytes in either direction, with acknowledge handling and address
// auto-increment. Assumes events from i2cs_cond are single-cycle and
// that reg_rdata follows reg_addr combinationally.
module i2cs_ctrl
    import i2cs_pkg::*;
#(
    parameter int ADDR_W  = 2,
    parameter int STRAP_W = 2,
    parameter logic [BYTE_W-2-STRAP_W:0] ID_PREFIX = 5'b01010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_s,
    input  logic               sda_s,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic               scl_rise_i,
    input  logic               scl_fall_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [BYTE_W-1:0]  reg_rdata,
    output logic               sda_oe,
    output logic [ADDR_W-1:0]  reg_addr,
    output logic               reg_wr,
    output logic [BYTE_W-1:0]  reg_wdata
);
    localparam int PREFIX_W = BYTE_W - 1 - STRAP_W;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

    phase_e            state;
    kind_e             kind;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              is_read;
    logic              mst_ack;
    logic              id_match;

    assign id_match = (rx_sh[BYTE_W-1 -: PREFIX_W] == ID_PREFIX) &&
                      (rx_sh[STRAP_W:1] == strap_i);

    // Bus phase sequencing, shifting and register port control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            kind      <= K_ID;
            cnt       <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            is_read   <= 1'b0;
            mst_ack   <= 1'b0;
            sda_oe    <= 1'b0;
            reg_addr  <= '0;
            reg_wr    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            reg_wr <= 1'b0;
            if (stop_i) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (start_i) begin
                state  <= ST_RX;
                kind   <= K_ID;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise_i && cnt != LAST) begin
                            rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall_i && cnt == LAST) begin
                            case (kind)
                                K_ID: begin
                                    if (id_match) begin
                                        is_read <= rx_sh[0];
                                        sda_oe  <= 1'b1;
                                        state   <= ST_ACK;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                K_ADDR: begin
                                    reg_addr <= rx_sh[ADDR_W-1:0];
                                    sda_oe   <= 1'b1;
                                    state    <= ST_ACK;
                                end
                                default: begin
                                    reg_wr    <= 1'b1;
                                    reg_wdata <= rx_sh;
                                    sda_oe    <= 1'b1;
                                    state     <= ST_ACK;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall_i) begin
                            cnt <= '0;
                            case (kind)
                                K_ID: begin
                                    kind   <= K_ADDR;
                                    sda_oe <= 1'b0;
                                    state  <= ST_RX;
                                end
                                K_ADDR: begin
                                    if (is_read) begin
                                        tx_sh  <= reg_rdata;
                                        sda_oe <= ~reg_rdata[BYTE_W-1];
                                        state  <= ST_TX;
                                    end else begin
                                        kind   <= K_DATA;
                                        sda_oe <= 1'b0;
                                        state  <= ST_RX;
                                    end
                                end
                                default: begin
                                    reg_addr <= reg_addr + 1'b1;
                                    sda_oe   <= 1'b0;
                                    state    <= ST_RX;
                                end
                            endcase
                        end
                    end
                    ST_TX: begin
                        if (scl_rise_i) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall_i) begin
                            if (cnt == LAST) begin
                                sda_oe   <= 1'b0;
                                reg_addr <= reg_addr + 1'b1;
                                state    <= ST_RACK;
                            end else begin
                                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx_sh[BYTE_W-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise_i) begin
                            mst_ack <= ~sda_s;
                        end else if (scl_fall_i) begin
                            if (mst_ack) begin
                                cnt    <= '0;
                                tx_sh  <= reg_rdata;
                                sda_oe <= ~reg_rdata[BYTE_W-1];
                                state  <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Drive only begins while SCL is low
    assert_oe_rise_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // Write strobe never lasts two cycles
    assert_wr_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // Idle slave never holds SDA
    assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // STOP always lands in idle
    assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (state == ST_IDLE));

    // A START restarts byte reception with SDA released
    assert_start_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state == ST_RX && kind == K_ID && cnt == '0 && !sda_oe));
endmodule

// File: rtl/i2cs_regport.sv
// Top of the two-wire register slave: synchronizer, bus event detector
// and transaction controller. Assumes the bus runs several times slower
// than clk so each SCL level spans at least four clock cycles.
module i2cs_regport #(
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        strap_i,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic [7:0]        reg_wdata,
    input  logic [7:0]        reg_rdata
);
    logic [1:0] lines_s;
    logic       primed;
    logic       start, stop, scl_rise, scl_fall;

    i2cs_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_i     ({sda_i, scl_i}),
        .out_o    (lines_s),
        .primed_o (primed)
    );

    i2cs_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .primed_i   (primed),
        .scl_s      (lines_s[0]),
        .sda_s      (lines_s[1]),
        .start_o    (start),
        .stop_o     (stop),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall)
    );

    i2cs_ctrl #(.ADDR_W(ADDR_W), .STRAP_W(2), .ID_PREFIX(5'b01010)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (lines_s[0]),
        .sda_s      (lines_s[1]),
        .start_i    (start),
        .stop_i     (stop),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .strap_i    (strap_i),
        .reg_rdata  (reg_rdata),
        .sda_oe     (sda_oe),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata)
    );
endmodule

// File: tb/i2cs_regport_tb.sv
module i2cs_regport_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic       sda_oe;
    logic [1:0] reg_addr;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       bus_sda;
    logic [7:0] bank [4];
    logic [7:0] model [4];
    int         n_run = 0;
    int         n_fail = 0;

    always #2 clk = ~clk;

    assign bus_sda = sda_m & ~sda_oe;

    i2cs_regport u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (bus_sda),
        .strap_i   (strap),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    // Register bank model seen by the slave
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) bank[i] <= 8'hA0 + 8'(i);
        end else if (reg_wr) begin
            bank[reg_addr] <= reg_wdata;
        end
    end
    assign reg_rdata = bank[reg_addr];

    // {id7, ack expected, address, data}
    localparam logic [23:0] VECS [6] = '{
        24'h55005C, 24'h5502E1, 24'h560133,
        24'hD40344, 24'h55079F, 24'h550100
    };

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wclk(4);
        scl_m = 1'b1; wclk(8);
        sda_m = 1'b0; wclk(8);
        scl_m = 1'b0; wclk(4);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wclk(4);
        scl_m = 1'b1; wclk(8);
        sda_m = 1'b1; wclk(8);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b;    wclk(4);
        scl_m = 1'b1; wclk(8);
        scl_m = 1'b0; wclk(4);
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; wclk(4);
        scl_m = 1'b1; wclk(4);
        b = bus_sda;  wclk(4);
        scl_m = 1'b0; wclk(4);
    endtask

    task automatic byte_out(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(b);
        acked = ~b;
    endtask

    task automatic byte_in(output logic [7:0] d, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            d[i] = b;
        end
        bit_out(~give_ack);
    endtask

    task automatic read_one(input logic [7:0] a, output logic [7:0] d);
        logic ak;
        bus_start();
        byte_out(8'h55, ak);
        byte_out(a, ak);
        byte_in(d, 1'b0);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic       ak;
        logic       b;
        logic [7:0] d;
        for (int i = 0; i < 4; i++) model[i] = 8'hA0 + 8'(i);
        wclk(6);
        check("R2 reset oe", 32'(sda_oe), 32'd0);
        check("R2 reset wr", 32'(reg_wr), 32'd0);
        rst_n = 1'b1;
        wclk(10);

        // Vector table: write then read back (R1 R3 R4 R5 R6 R7)
        for (int v = 0; v < 6; v++) begin
            logic [6:0] id7;
            logic       exp_ack;
            logic [7:0] a, dv;
            {id7, exp_ack, a, dv} = VECS[v];
            bus_start();
            byte_out({id7, 1'b0}, ak);
            check(exp_ack ? "R3 id ack" : "R4 id nack", 32'(ak), 32'(exp_ack));
            byte_out(a, ak);
            check(exp_ack ? "R5 addr ack" : "R4 addr ignored", 32'(ak), 32'(exp_ack));
            byte_out(dv, ak);
            check(exp_ack ? "R6 data ack" : "R4 data ignored", 32'(ak), 32'(exp_ack));
            bus_stop();
            if (exp_ack) model[a[1:0]] = dv;
            read_one(a, d);
            check("R7 R1 readback", 32'(d), 32'(model[a[1:0]]));
        end

        // Write across the wrap: strobe and ACK share a falling edge (R6 R8)
        bus_start();
        byte_out(8'h54, ak);
        byte_out(8'h03, ak);
        byte_out(8'h11, ak);
        check("R6 wrap data0 ack", 32'(ak), 32'd1);
        byte_out(8'h22, ak);
        check("R6 wrap data1 ack", 32'(ak), 32'd1);
        bus_stop();
        model[3] = 8'h11;
        model[0] = 8'h22;

        // Burst read across the wrap (R7 R8)
        bus_start();
        byte_out(8'h55, ak);
        byte_out(8'h03, ak);
        check("R5 read addr ack", 32'(ak), 32'd1);
        byte_in(d, 1'b1);
        check("R8 read reg3", 32'(d), 32'(model[3]));
        byte_in(d, 1'b1);
        check("R8 read wrap reg0", 32'(d), 32'(model[0]));
        byte_in(d, 1'b0);
        check("R8 read reg1", 32'(d), 32'(model[1]));
        // After NACK the slave stays off the bus (R7)
        bit_in(b);
        check("R7 released after nack", 32'(b), 32'd1);
        bit_in(b);
        check("R7 still released", 32'(b), 32'd1);
        bus_stop();

        // Repeated START mid data byte (R10)
        bus_start();
        byte_out(8'h54, ak);
        byte_out(8'h01, ak);
        for (int i = 0; i < 4; i++) bit_out(1'b0);
        bus_start();
        byte_out(8'h54, ak);
        check("R10 new id ack", 32'(ak), 32'd1);
        byte_out(8'h02, ak);
        byte_out(8'h77, ak);
        bus_stop();
        model[2] = 8'h77;
        read_one(8'h01, d);
        check("R10 partial byte not written", 32'(d), 32'(model[1]));
        read_one(8'h02, d);
        check("R10 new write landed", 32'(d), 32'(model[2]));

        // After STOP, clocking without START is ignored (R9)
        scl_m = 1'b0; wclk(4);
        byte_out(8'h54, ak);
        check("R9 idle after stop", 32'(ak), 32'd0);
        check("R9 oe released", 32'(sda_oe), 32'd0);
        bus_stop();

        // START during reset is not recognized (R2)
        rst_n = 1'b0;
        wclk(4);
        sda_m = 1'b0;
        wclk(8);
        rst_n = 1'b1;
        wclk(12);
        check("R2 oe after reset", 32'(sda_oe), 32'd0);
        scl_m = 1'b0; wclk(4);
        byte_out(8'h54, ak);
        check("R2 reset start ignored", 32'(ak), 32'd0);
        bus_stop();

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule